// File: doc/BRIEF.md
# Eight-Bit Dual-Channel Compare Timer

This block is an 8-bit up-counter that steps once for each cycle on which a single-cycle tick input is high. Two compare channels, A and B, each hold a compare value that is checked against the count on every tick. A hit sets that channel's event flag and, according to a 2-bit action field, toggles, clears, sets or leaves alone the channel's waveform output. The counter either runs freely and wraps with an overflow event, or returns to zero after it reaches compare value A.

Software reaches the block through a small synchronous register port. It can read and write the count, both compare values and the control fields. It can clear event flags by writing ones to them. It can also fire per-channel force strobes, which apply the channel's action to its output without raising a flag. Writing the count suppresses compare hits on the tick that follows, so reloading the counter never produces a stray event.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: After synchronous reset the count, both compare values, the control register, all event flags and both waveform outputs are zero.
- R2: The register port has these word addresses: 0 control, 1 force strobe, 2 count, 3 compare A, 4 compare B, 5 flags. Control bits [1:0] select the counter mode, bits [3:2] hold the channel A action and bits [5:4] the channel B action. A write to the control, count or compare registers is read back unchanged from the next cycle on, and the read data is combinational on the address.
- R3: The count changes only on a cycle with tick_en high or a count write. In free-running mode (mode 00) it steps from 255 to 0, and every step from 255 to 0 sets flag bit 0 (overflow).
- R4: A tick on which the count equals compare value A sets flag bit 1, and the same for B sets flag bit 2. Writing ones to the flags address clears the matching bits. A set on the same edge wins over the clear.
- R5: On a compare hit the channel output follows its action code: 00 leaves it unchanged, 01 toggles it, 10 drives it to 0, 11 drives it to 1. The output changes on the clock edge of the hitting tick.
- R6: In clear-on-match mode (mode 01), a tick with a compare A hit loads the count with 0 instead of incrementing it.
- R7: Writing a one to bit 0 (A) or bit 1 (B) of the force address applies that channel's action to its output at the write's clock edge. A force sets no flag and does not change the count, including in mode 01.
- R8: The force address always reads as zero.
- R9: In modes 10 and 11 (pulse-width codes) force writes leave both outputs unchanged.
- R10: After a count write, the next tick produces no compare hit: no flag is set, no output changes and no clear-on-match happens. The count still increments and overflow still applies.
- R11: When a force and a compare hit reach the same channel on the same edge, the action is applied once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle count enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |

## Verification
The bound checker checks, on every cycle, the rules that tie one edge to the next. These are count stability without a tick, the 255-to-0 wrap with its overflow flag, clear-on-match, force leaving count and flags alone, force being ignored in pulse-width codes, a disconnected action holding the output, the force address reading zero, and the post-write suppression of flags. Only the bench's scenarios can show that each action code produces the right output level over a sequence of hits and forces. They also show that a blocked tick skips the clear so the counter runs past compare A, and that a force coinciding with a hit toggles just once.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_FORCE = 3'd1;
    localparam logic [ADDR_W-1:0] REG_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] REG_CMPA  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_CMPB  = 3'd4;
    localparam logic [ADDR_W-1:0] REG_FLAGS = 3'd5;

    localparam int FLG_OVF  = 0;
    localparam int FLG_CMPA = 1;
    localparam int FLG_CMPB = 2;
    localparam int NUM_FLG  = 3;
    localparam int NUM_CH   = 2;

    typedef enum logic [1:0] {
        WG_FREE = 2'b00,
        WG_CTC  = 2'b01,
        WG_PW0  = 2'b10,
        WG_PW1  = 2'b11
    } wgen_mode_e;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } out_act_e;

    typedef struct packed {
        out_act_e   act_b;
        out_act_e   act_a;
        wgen_mode_e mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic hit_b;
        logic hit_a;
        logic ovf;
    } evt_t;

    function automatic logic apply_act(input out_act_e act, input logic cur);
        logic nxt;
        case (act)
            ACT_TOGGLE: nxt = ~cur;
            ACT_CLEAR:  nxt = 1'b0;
            ACT_SET:    nxt = 1'b1;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic is_pw_mode(input wgen_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  wgen_mode_e   mode,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         top_hit,
    output logic [W-1:0] count,
    output logic         eval,
    output logic         ovf_evt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         blk_q;

    assign eval    = tick_en & ~load & ~blk_q;
    assign ovf_evt = tick_en & ~load & (cnt_q == CNT_MAX);
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            blk_q <= 1'b1;
        end else if (tick_en) begin
            blk_q <= 1'b0;
            if (mode == WG_CTC && top_hit)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr8_cmp_chan.sv
module tmr8_cmp_chan
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         eval,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp_val,
    input  out_act_e     act,
    input  logic         force_hit,
    output logic         match_evt,
    output logic         wave
);
    logic wave_q;

    assign match_evt = eval & (count == cmp_val);
    assign wave      = wave_q;

    always_ff @(posedge clk) begin
        if (rst)
            wave_q <= 1'b0;
        else if (match_evt | force_hit)
            wave_q <= apply_act(act, wave_q);
    end
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      count,
    input  evt_t              evt,
    output logic [W-1:0]      bus_rdata,
    output ctrl_t             ctrl,
    output logic [W-1:0]      cmp_a,
    output logic [W-1:0]      cmp_b,
    output logic [NUM_FLG-1:0] flags,
    output logic [NUM_CH-1:0] force_hit,
    output logic              cnt_load
);
    ctrl_t              ctrl_q;
    logic [W-1:0]       cmpa_q, cmpb_q;
    logic [NUM_FLG-1:0] flg_q, flg_set, flg_clr;
    logic               wr_ctrl, wr_cmpa, wr_cmpb, wr_flags, wr_force;

    assign wr_ctrl  = bus_we && bus_addr == REG_CTRL;
    assign wr_cmpa  = bus_we && bus_addr == REG_CMPA;
    assign wr_cmpb  = bus_we && bus_addr == REG_CMPB;
    assign wr_flags = bus_we && bus_addr == REG_FLAGS;
    assign wr_force = bus_we && bus_addr == REG_FORCE;
    assign cnt_load = bus_we && bus_addr == REG_COUNT;

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_force
            assign force_hit[k] = wr_force & bus_wdata[k] & ~is_pw_mode(ctrl_q.mode);
        end
    endgenerate

    assign flg_set[FLG_OVF]  = evt.ovf;
    assign flg_set[FLG_CMPA] = evt.hit_a;
    assign flg_set[FLG_CMPB] = evt.hit_b;
    assign flg_clr = wr_flags ? bus_wdata[NUM_FLG-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
            flg_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_cmpa) cmpa_q <= bus_wdata;
            if (wr_cmpb) cmpb_q <= bus_wdata;
            flg_q <= (flg_q & ~flg_clr) | flg_set;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL:  bus_rdata[CTRL_W-1:0]  = ctrl_q;
            REG_COUNT: bus_rdata               = count;
            REG_CMPA:  bus_rdata               = cmpa_q;
            REG_CMPB:  bus_rdata               = cmpb_q;
            REG_FLAGS: bus_rdata[NUM_FLG-1:0] = flg_q;
            default:   bus_rdata               = '0;
        endcase
    end

    assign ctrl  = ctrl_q;
    assign cmp_a = cmpa_q;
    assign cmp_b = cmpb_q;
    assign flags = flg_q;
endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              wave_a,
    output logic              wave_b
);
    ctrl_t              ctrl_w;
    logic [W-1:0]       count_w, cmpa_w, cmpb_w;
    logic [NUM_FLG-1:0] flags_w;
    logic [NUM_CH-1:0]  force_w, match_w, wave_w;
    logic               load_w, eval_w, ovf_w;
    evt_t               evt_w;

    logic [W-1:0]       cmp_arr [NUM_CH];
    out_act_e           act_arr [NUM_CH];

    assign cmp_arr[0] = cmpa_w;
    assign cmp_arr[1] = cmpb_w;
    assign act_arr[0] = ctrl_w.act_a;
    assign act_arr[1] = ctrl_w.act_b;

    assign evt_w.ovf   = ovf_w;
    assign evt_w.hit_a = match_w[0];
    assign evt_w.hit_b = match_w[1];

    tmr8_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count_w),
        .evt       (evt_w),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl_w),
        .cmp_a     (cmpa_w),
        .cmp_b     (cmpb_w),
        .flags     (flags_w),
        .force_hit (force_w),
        .cnt_load  (load_w)
    );

    tmr8_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .mode     (ctrl_w.mode),
        .load     (load_w),
        .load_val (bus_wdata),
        .top_hit  (match_w[0]),
        .count    (count_w),
        .eval     (eval_w),
        .ovf_evt  (ovf_w)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            tmr8_cmp_chan #(.W(W)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .eval      (eval_w),
                .count     (count_w),
                .cmp_val   (cmp_arr[c]),
                .act       (act_arr[c]),
                .force_hit (force_w[c]),
                .match_evt (match_w[c]),
                .wave      (wave_w[c])
            );
        end
    endgenerate

    assign wave_a = wave_w[0];
    assign wave_b = wave_w[1];
endmodule

// File: rtl/tmr8_dual_cmp_chk.sv
module tmr8_dual_cmp_chk
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic              wave_a,
    input logic              wave_b,
    input logic [W-1:0]      count,
    input logic [W-1:0]      cmpa,
    input logic [NUM_FLG-1:0] flags,
    input ctrl_t             ctrl,
    input logic              blk
);
    logic cnt_wr, frc_wr;
    assign cnt_wr = bus_we && bus_addr == REG_COUNT;
    assign frc_wr = bus_we && bus_addr == REG_FORCE;

    assert_strobe_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_FORCE) |-> (bus_rdata == '0));

    assert_count_load_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count == $past(bus_wdata)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cnt_wr) |=> $stable(count));

    assert_wrap_ovf_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cnt_wr && count == {W{1'b1}}) |=> (count == '0 && flags[FLG_OVF]));

    assert_ctc_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == WG_CTC && tick_en && !blk && !cnt_wr && count == cmpa) |=> (count == '0));

    assert_force_count_R7: assert property (@(posedge clk) disable iff (rst)
        (frc_wr && !tick_en) |=> (count == $past(count)));

    assert_force_noflag_R7: assert property (@(posedge clk) disable iff (rst)
        (frc_wr && !tick_en) |=> (flags == $past(flags)));

    assert_pw_force_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode[1] && frc_wr && !tick_en) |=> ($stable(wave_a) && $stable(wave_b)));

    assert_off_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.act_a == ACT_OFF) |=> $stable(wave_a));

    assert_block_noflag_R10: assert property (@(posedge clk) disable iff (rst)
        (blk && tick_en && !cnt_wr && flags[FLG_CMPA] == 1'b0 && flags[FLG_CMPB] == 1'b0)
        |=> (flags[FLG_CMPA] == 1'b0 && flags[FLG_CMPB] == 1'b0));
endmodule

bind tmr8_dual_cmp tmr8_dual_cmp_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wave_a    (wave_a),
    .wave_b    (wave_b),
    .count     (count_w),
    .cmpa      (cmpa_w),
    .flags     (flags_w),
    .ctrl      (ctrl_w),
    .blk       (u_cnt.blk_q)
);

// File: tb/test_tmr8_dual_cmp.sv
`timescale 1ns/1ps
module test_tmr8_dual_cmp;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       wave_a, wave_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int         q_kind [$];
    logic [7:0] q_exp  [$];
    string      q_tag  [$];

    always #2.5 clk = ~clk;

    tmr8_dual_cmp i_tmr8_dual_cmp (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wave_a(wave_a), .wave_b(wave_b)
    );

    // Monitor: pops one expected item per falling edge and compares it.
    always @(negedge clk) begin
        if (q_kind.size() != 0) begin
            int k;
            logic [7:0] e, act;
            string t;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            act = (k == 1) ? {6'd0, wave_b, wave_a} : bus_rdata;
            checks++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s: actual=%02h expected=%02h", t, act, e);
            end
        end
    end

    // Driver tasks: each starts and ends 1 ns after a rising edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic tk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(posedge clk); #1;
        bus_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(posedge clk); #1;
        end
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic exp_reg(input logic [2:0] a, input logic [7:0] e, input string t);
        bus_addr = a;
        q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
        @(posedge clk); #1;
    endtask

    task automatic exp_wave(input logic wa, input logic wb, input string t);
        q_kind.push_back(1); q_exp.push_back({6'd0, wb, wa}); q_tag.push_back(t);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        exp_reg(3'd2, 8'h00, "R1 count");
        exp_reg(3'd3, 8'h00, "R1 cmpa");
        exp_reg(3'd0, 8'h00, "R1 ctrl");
        exp_reg(3'd5, 8'h00, "R1 flags");
        exp_wave(1'b0, 1'b0, "R1 waves");

        // R2: register readback; free mode, both toggle
        wr(3'd3, 8'h40, 1'b0);
        wr(3'd4, 8'h80, 1'b0);
        wr(3'd0, 8'h14, 1'b0);
        exp_reg(3'd0, 8'h14, "R2 ctrl");
        exp_reg(3'd3, 8'h40, "R2 cmpa");
        exp_reg(3'd4, 8'h80, "R2 cmpb");

        // R3: ticks only advance
        wr(3'd2, 8'h10, 1'b0);
        ticks(5);
        exp_reg(3'd2, 8'h15, "R3 count after ticks");
        idle(4);
        exp_reg(3'd2, 8'h15, "R3 count holds without tick");

        // R4/R5: match A toggles
        wr(3'd2, 8'h3E, 1'b0);
        ticks(3);
        exp_reg(3'd2, 8'h41, "R4 count past match");
        exp_reg(3'd5, 8'h02, "R4 flag A set");
        exp_wave(1'b1, 1'b0, "R5 toggle A");
        wr(3'd5, 8'h02, 1'b0);
        exp_reg(3'd5, 8'h00, "R4 flag cleared");

        // R3: wrap and overflow
        wr(3'd2, 8'hFE, 1'b0);
        ticks(2);
        exp_reg(3'd2, 8'h00, "R3 wrap");
        exp_reg(3'd5, 8'h01, "R3 overflow flag");
        wr(3'd5, 8'h01, 1'b0);

        // R10: write equal to cmpa, next tick blocked
        wr(3'd2, 8'h40, 1'b0);
        ticks(1);
        exp_reg(3'd2, 8'h41, "R10 count increments");
        exp_reg(3'd5, 8'h00, "R10 no flag");
        exp_wave(1'b1, 1'b0, "R10 no toggle");

        // R5: clear on A, set on B
        wr(3'd0, 8'h38, 1'b0);
        wr(3'd2, 8'h3F, 1'b0);
        ticks(2);
        wr(3'd2, 8'h7F, 1'b0);
        ticks(2);
        exp_wave(1'b0, 1'b1, "R5 clear A set B");
        exp_reg(3'd5, 8'h06, "R4 flags A and B");
        wr(3'd5, 8'h06, 1'b0);

        // R5: disconnected action
        wr(3'd0, 8'h00, 1'b0);
        wr(3'd2, 8'h3F, 1'b0);
        ticks(2);
        exp_wave(1'b0, 1'b1, "R5 off holds");
        exp_reg(3'd5, 8'h02, "R4 flag with action off");
        wr(3'd5, 8'h02, 1'b0);

        // R7/R8: force in free mode (A toggle, B clear)
        wr(3'd0, 8'h24, 1'b0);
        wr(3'd1, 8'h03, 1'b0);
        exp_wave(1'b1, 1'b0, "R7 force actions");
        exp_reg(3'd5, 8'h00, "R7 force no flag");
        exp_reg(3'd2, 8'h41, "R7 force keeps count");
        exp_reg(3'd1, 8'h00, "R8 strobe reads zero");

        // R7: force in clear-on-match mode
        wr(3'd0, 8'h25, 1'b0);
        wr(3'd1, 8'h01, 1'b0);
        exp_wave(1'b0, 1'b0, "R7 force in ctc");
        exp_reg(3'd2, 8'h41, "R7 ctc force no clear");

        // R6: clear on match
        wr(3'd2, 8'h3E, 1'b0);
        ticks(3);
        exp_reg(3'd2, 8'h00, "R6 ctc clear");
        exp_reg(3'd5, 8'h02, "R6 flag A");
        exp_wave(1'b1, 1'b0, "R6 toggle on clear");
        ticks(1);
        exp_reg(3'd2, 8'h01, "R6 resumes");
        wr(3'd5, 8'h02, 1'b0);

        // R10: blocked tick skips the clear
        wr(3'd2, 8'h40, 1'b0);
        ticks(1);
        exp_reg(3'd2, 8'h41, "R10 ctc clear skipped");
        exp_reg(3'd5, 8'h00, "R10 ctc no flag");

        // R9: force ignored in pulse-width codes
        wr(3'd0, 8'h36, 1'b0);
        wr(3'd1, 8'h03, 1'b0);
        exp_wave(1'b1, 1'b0, "R9 force ignored");
        exp_reg(3'd5, 8'h00, "R9 no flag");

        // R11: force and match on the same edge toggle once
        wr(3'd0, 8'h04, 1'b0);
        wr(3'd2, 8'h3F, 1'b0);
        ticks(1);
        wr(3'd1, 8'h01, 1'b1);
        exp_wave(1'b0, 1'b0, "R11 single toggle");
        exp_reg(3'd5, 8'h02, "R11 flag from match");
        exp_reg(3'd2, 8'h41, "R11 count advanced");

        idle(2);
        if (q_kind.size() != 0) begin
            errors++;
            $display("FAIL scoreboard drain: actual=%0d expected=0", q_kind.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule